// File: doc/BRIEF.md
# Pin-Mode / Serial-Mode Selector

This block decides what the shared control pins of a device mean. After a hard reset the chip-select, serial clock, bidirectional data pin and output-data pad act as direct configuration inputs: their levels are synchronised to the core clock and drive the core configuration bits straight away. A small watcher keeps observing the same pins. It counts serial clock rising edges while chip select is held low.

When a complete instruction byte has been clocked in during one chip-select window, the selector moves its output multiplexer to the serial register values for good. From then on the core is configured through the serial port, and pin levels no longer reach the configuration outputs. A board that ties chip select high therefore stays in pin mode forever. A host that talks to the port switches it without any strap pin.

The output-data pad enable is gated so that the pad stays high impedance in pin mode and whenever chip select is high.

Top module: `pinmode_selector`

## Requirements
- R1: After a hard reset (`rst_n_i` low), `serial_mode_o` is 0, `sdo_oe_o` is 0 and `cfg_o` is all zero while the pins are low.
- R2: In pin mode, `cfg_o` bit 0 follows the serial clock pin, bit 1 the data pin and bit 2 the output-data pad (the number of bits is set by `NUM_CTRL`).
- R3: A pin level change reaches `cfg_o` and `pin_bits_o` after exactly two rising core clock edges, and not after one.
- R4: Serial clock activity while chip select is high never changes the mode.
- R5: Raising chip select before the instruction byte is complete discards the partial edge count, so a later window needs a full instruction byte of its own.
- R6: The mode switches to serial once `INSTR_BITS` (default 8) serial clock rising edges have been seen within one low chip-select window, and not after `INSTR_BITS`-1 edges.
- R7: In serial mode, `cfg_o` equals `reg_ctrl_i`, and pin levels have no effect on it.
- R8: `sdo_oe_o` is high only when the block is in serial mode, `csb_i` is low and `eng_sdo_oe_i` is high; otherwise the pad is high impedance.
- R9: A `soft_rst_i` pulse does not return the block to pin mode; only a hard reset does.
- R10: Once serial mode is selected, it holds for the rest of operation, whatever the pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_n_i | input | 1 | Hard reset, asynchronous assert, active low |
| soft_rst_i | input | 1 | Soft reset pulse, synchronous to the core clock |
| csb_i | input | 1 | Chip select pin, active low |
| sclk_i | input | 1 | Serial clock pin, pin-mode control bit 0 |
| sdio_i | input | 1 | Bidirectional data pin input path, pin-mode control bit 1 |
| sdo_pad_i | input | 1 | Output-data pad input path, pin-mode control bit 2 |
| eng_sdo_oe_i | input | 1 | Output-enable request from the serial engine |
| reg_ctrl_i | input | NUM_CTRL | Control bits held in the serial registers |
| serial_mode_o | output | 1 | Multiplexer select: 0 pin mode, 1 serial mode |
| pin_bits_o | output | NUM_CTRL | Synchronised pin-derived control bits |
| cfg_o | output | NUM_CTRL | Control bits delivered to the core |
| sdo_oe_o | output | 1 | Output-data pad enable |

## Verification
The bench aims at the instruction boundary. It checks that seven edges leave pin mode in place and that the eighth switches it. A counter that is off by one would switch one edge early or late. It also aborts a frame midway and then sends a short second frame. A design that kept the partial count across windows would switch there by mistake. Clock toggling with chip select high, soft reset pulses and pin wiggling after the switch all target the sticky behaviour, which a leaky selector would drop back to pin mode. The two-edge synchroniser latency is sampled on both sides, so a missing or extra stage shows up as early or late pin data.

// File: rtl/pinsel_pkg.sv
package pinsel_pkg;

  typedef enum logic {
    MODE_PIN    = 1'b0,
    MODE_SERIAL = 1'b1
  } sel_mode_e;

  localparam int unsigned MAX_CTRL = 3;

endpackage

// File: rtl/pinsel_rst_sync.sv
module pinsel_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/pinsel_sync.sv
module pinsel_sync #(
  parameter int unsigned        WIDTH   = 4,
  parameter int unsigned        STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_rest
      assign stage_d = stage_q[s-1];
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
        stage_q[s] <= RST_VAL;
      end else begin
        stage_q[s] <= stage_d;
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pinsel_edge_counter.sv
module pinsel_edge_counter #(
  parameter int unsigned INSTR_BITS = 8,
  localparam int unsigned CNT_W     = $clog2(INSTR_BITS + 1)
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic soft_rst_i,
  input  logic csb_s_i,
  input  logic sclk_s_i,
  output logic instr_seen_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(INSTR_BITS - 1);

  logic             sclk_prev_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             seen_q, seen_d;
  logic             rise;
  logic             cnt_en;

  assign rise   = sclk_s_i & ~sclk_prev_q;
  assign cnt_en = rise & ~csb_s_i;

  always_comb begin
    cnt_d  = cnt_q;
    seen_d = 1'b0;
    if (csb_s_i || soft_rst_i) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      if (cnt_q == LAST) begin
        seen_d = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sclk_prev_q <= 1'b0;
      cnt_q       <= '0;
      seen_q      <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_s_i;
      cnt_q       <= cnt_d;
      seen_q      <= seen_d;
    end
  end

  assign instr_seen_o = seen_q;

  // R5: the partial count never passes the last bit position
  a_r5_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    cnt_q <= LAST);

  // R6: an instruction report is a single-cycle event
  a_r6_seen_single: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    seen_q |=> !seen_q);

  // R4: no report while chip select was high on the previous cycle
  a_r4_csb_high_quiet: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    csb_s_i |=> !seen_q);

endmodule

// File: rtl/pinsel_mode_latch.sv
module pinsel_mode_latch
  import pinsel_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_n_i,
  input  logic      instr_seen_i,
  output sel_mode_e mode_o
);

  sel_mode_e mode_q, mode_d;
  logic      set_en;

  assign set_en = instr_seen_i & (mode_q == MODE_PIN);

  always_comb begin
    mode_d = mode_q;
    if (set_en) begin
      mode_d = MODE_SERIAL;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      mode_q <= MODE_PIN;
    end else begin
      mode_q <= mode_d;
    end
  end

  assign mode_o = mode_q;

  // R10: serial mode is never left without a hard reset
  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (mode_q == MODE_SERIAL) |=> (mode_q == MODE_SERIAL));

  // R6: entering serial mode requires a recognised instruction
  a_r6_cause: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(mode_q == MODE_SERIAL) |-> $past(instr_seen_i));

endmodule

// File: rtl/pinmode_selector.sv
module pinmode_selector
  import pinsel_pkg::*;
#(
  parameter int unsigned NUM_CTRL    = 3,
  parameter int unsigned INSTR_BITS  = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SYNC_W     = NUM_CTRL + 1
) (
  input  logic                clk_i,
  input  logic                rst_n_i,
  input  logic                soft_rst_i,
  input  logic                csb_i,
  input  logic                sclk_i,
  input  logic                sdio_i,
  input  logic                sdo_pad_i,
  input  logic                eng_sdo_oe_i,
  input  logic [NUM_CTRL-1:0] reg_ctrl_i,
  output logic                serial_mode_o,
  output logic [NUM_CTRL-1:0] pin_bits_o,
  output logic [NUM_CTRL-1:0] cfg_o,
  output logic                sdo_oe_o
);

  logic                core_rst_n;
  logic [MAX_CTRL-1:0] pins_raw;
  logic [SYNC_W-1:0]   sync_d, sync_q;
  logic                csb_s;
  logic                instr_seen;
  sel_mode_e           mode;

  assign pins_raw = {sdo_pad_i, sdio_i, sclk_i};
  assign sync_d   = {pins_raw[NUM_CTRL-1:0], csb_i};

  pinsel_rst_sync #(
    .STAGES (2)
  ) u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (core_rst_n)
  );

  pinsel_sync #(
    .WIDTH   (SYNC_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SYNC_W'(1))
  ) u_sync (
    .clk_i   (clk_i),
    .rst_n_i (core_rst_n),
    .d_i     (sync_d),
    .q_o     (sync_q)
  );

  assign csb_s      = sync_q[0];
  assign pin_bits_o = sync_q[SYNC_W-1:1];

  pinsel_edge_counter #(
    .INSTR_BITS (INSTR_BITS)
  ) u_cnt (
    .clk_i        (clk_i),
    .rst_n_i      (core_rst_n),
    .soft_rst_i   (soft_rst_i),
    .csb_s_i      (csb_s),
    .sclk_s_i     (pin_bits_o[0]),
    .instr_seen_o (instr_seen)
  );

  pinsel_mode_latch u_mode (
    .clk_i        (clk_i),
    .rst_n_i      (core_rst_n),
    .instr_seen_i (instr_seen),
    .mode_o       (mode)
  );

  assign serial_mode_o = (mode == MODE_SERIAL);

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_cfg_mux
    assign cfg_o[i] = serial_mode_o ? reg_ctrl_i[i] : pin_bits_o[i];
  end

  assign sdo_oe_o = serial_mode_o & ~csb_i & eng_sdo_oe_i;

  // R8: the pad stays released while in pin mode
  a_r8_oe_pin_mode: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    !serial_mode_o |-> !sdo_oe_o);

  // R9: a soft reset leaves serial mode in place
  a_r9_soft_keeps: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    (serial_mode_o && soft_rst_i) |=> serial_mode_o);

  // R7: in serial mode the outputs move only with the register bits
  a_r7_regs_only: assert property (@(posedge clk_i) disable iff (!core_rst_n)
    (serial_mode_o && $past(serial_mode_o) && $stable(reg_ctrl_i)) |-> $stable(cfg_o));

endmodule

// File: tb/sim_pinmode_selector.sv
module sim_pinmode_selector;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 3;

  typedef struct {
    string req;
    int    kind;   // 0 mode, 1 cfg, 2 oe, 3 pin_bits
    int    exp;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n, soft_rst, csb, sclk, sdio, sdo_pad, eng_oe;
  logic [NC-1:0] reg_ctrl;
  logic          serial_mode, sdo_oe;
  logic [NC-1:0] pin_bits, cfg;

  item_t q[$];
  event  chk_ev;
  int    n_run = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinmode_selector #(.NUM_CTRL(NC), .INSTR_BITS(8), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_n_i(rst_n), .soft_rst_i(soft_rst), .csb_i(csb),
    .sclk_i(sclk), .sdio_i(sdio), .sdo_pad_i(sdo_pad), .eng_sdo_oe_i(eng_oe),
    .reg_ctrl_i(reg_ctrl), .serial_mode_o(serial_mode), .pin_bits_o(pin_bits),
    .cfg_o(cfg), .sdo_oe_o(sdo_oe)
  );

  // monitor: pops expectations and compares at the falling edge
  initial begin
    forever begin
      @(chk_ev);
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        int act;
        it = q.pop_front();
        case (it.kind)
          0: act = int'(serial_mode);
          1: act = int'(cfg);
          2: act = int'(sdo_oe);
          default: act = int'(pin_bits);
        endcase
        n_run++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d actual=%0d expected=%0d", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic push(string req, int kind, int exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic flush();
    ->chk_ev;
    wait (q.size() == 0);
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic sclk_pulses(int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1; cyc(4);
      sclk = 1'b0; cyc(4);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; soft_rst = 1'b0; csb = 1'b1; sclk = 1'b0; sdio = 1'b0;
    sdo_pad = 1'b0; eng_oe = 1'b0; reg_ctrl = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    // R1 reset state
    push("R1", 0, 0); push("R1", 2, 0); push("R1", 1, 0); flush();

    // R2 pin mode mapping, two patterns
    sclk = 1'b1; sdio = 1'b0; sdo_pad = 1'b1; cyc(5);
    push("R2", 1, 5); push("R2", 3, 5); flush();
    sclk = 1'b0; sdio = 1'b1; sdo_pad = 1'b0; cyc(5);
    push("R2", 1, 2); flush();

    // R3 two-edge latency
    sdo_pad = 1'b1;
    @(posedge clk);
    push("R3", 1, 2); flush();
    @(posedge clk);
    push("R3", 1, 6); flush();
    sdo_pad = 1'b0; sdio = 1'b0; cyc(4);

    // R4 clocks with chip select high
    sclk_pulses(12); cyc(6);
    push("R4", 0, 0); flush();

    // R5 aborted frame, then short frame
    csb = 1'b0; cyc(4);
    sclk_pulses(5);
    csb = 1'b1; cyc(6);
    csb = 1'b0; cyc(4);
    sclk_pulses(3); cyc(6);
    push("R5", 0, 0); flush();
    csb = 1'b1; cyc(6);

    // R6 boundary: seven edges keep pin mode, eighth switches
    eng_oe = 1'b1;
    csb = 1'b0; cyc(4);
    sclk_pulses(7); cyc(6);
    push("R6", 0, 0); push("R8", 2, 0); flush();
    sclk_pulses(1); cyc(6);
    push("R6", 0, 1); flush();

    // R8 output enable with serial mode and chip select low
    push("R8", 2, 1); flush();
    eng_oe = 1'b0; #1;
    push("R8", 2, 0); flush();
    eng_oe = 1'b1; csb = 1'b1; #1;
    push("R8", 2, 0); flush();

    // R7 registers drive the outputs, pins ignored
    reg_ctrl = 3'b011; sclk = 1'b0; sdio = 1'b0; sdo_pad = 1'b1; cyc(5);
    push("R7", 1, 3); flush();
    sdo_pad = 1'b0; sdio = 1'b1; sclk = 1'b1; cyc(5);
    push("R7", 1, 3); flush();
    reg_ctrl = 3'b100; cyc(1);
    push("R7", 1, 4); flush();

    // R9 soft reset keeps serial mode
    soft_rst = 1'b1; cyc(1); soft_rst = 1'b0; cyc(3);
    push("R9", 0, 1); flush();

    // R10 sticky under long chip select high and pin activity
    sclk = 1'b0; sclk_pulses(6); cyc(20);
    push("R10", 0, 1); flush();

    // R9 hard reset returns to pin mode
    rst_n = 1'b0; cyc(2); rst_n = 1'b1; cyc(4);
    push("R9", 0, 0); push("R1", 2, 0); flush();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule